// File: doc/BRIEF.md
# UART Automatic Flow Controller

This block sits beside a UART's transmitter, receive FIFO and modem pins and throttles traffic in both directions. On the transmit side it decides, one character at a time, whether the transmitter may launch the next character. It refuses a launch while the synchronized CTS input is high and automatic CTS is on, or while a software pause is in force. A character already being shifted out is never cut short, because the transmitter only asks for a launch when it is idle.

On the receive side it drives RTS from the FIFO fill level, with a threshold and a hysteresis gap. It inspects every received character before it is stored. An Xoff character pauses the transmitter and an Xon character resumes it; neither one enters the FIFO. A programmable special character is stored as normal and also raises a flag. The three flags (CTS event, RTS event, special character) stay set until they are cleared, and feed an interrupt controller through a small priority encoder.

The configuration registers can be written and read only while the line-control value presented to the block equals 0xBF.

Top module: `uart_flow_ctl`

## Requirements
- R1: After reset all flags are clear, `irq_src` is 0, `rts_n_pin` is 0 and `fifo_wr` is 0. The registers hold their defaults: feature 0x00, Xon 0x11, Xoff 0x13, special 0x00, RTS threshold 8.
- R2: Register access (address 0 feature, 1 Xon, 2 Xoff, 3 special, 4 RTS threshold) works only while `line_ctl` equals 0xBF. When `line_ctl` has any other value, writes leave the register unchanged and `cfg_rdata` reads 0.
- R3: When feature bit 7 (auto-CTS) is set, a high level on `cts_n_pin` blocks `tx_launch` from the second clock edge after the pin changes. A launch is granted again two edges after the pin returns low. `tx_launch` is only ever granted when both `tx_pending` and `tx_idle` are high.
- R4: A 0-to-1 change of the synchronized CTS with auto-CTS on sets `cts_flag` on the third edge after the pin changes, but only if `ie_flow[1]` is 1.
- R5: When feature bit 6 (auto-RTS) is set, `rts_n_pin` goes to 1 one edge after `rx_count` is at or above the threshold. It returns to 0 one edge after `rx_count` falls below threshold−4, or below 1 if the threshold is 4 or less. When bit 6 is clear, `rts_n_pin` is 0.
- R6: A 0-to-1 change of `rts_n_pin` sets `rts_flag` one edge later, but only if `ie_flow[0]` is 1.
- R7: When feature bit 4 (software flow) is set, a received Xoff character blocks `tx_launch` from the next edge and a received Xon character releases it. Neither character is written to the FIFO. When bit 4 is clear, both are ordinary data.
- R8: When feature bit 5 (special detect) is set, a received character equal to the special register is written to the FIFO and sets `spec_flag`. Bit i of the register is compared with bit i of the character, so 0x01 matches 0x01 and not 0x80.
- R9: Flags stay set until a `flag_clr` pulse; a new event in the same cycle wins over the clear. `irq_pend` is the OR of the flags. `irq_src` is 1 when `spec_flag` is set, otherwise 2 when a flow flag is set, otherwise 0.
- R10: Every received character that is not consumed as Xon or Xoff appears on `fifo_wr`/`fifo_wdata` one edge after `rx_valid`, in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_ctl | input | 8 | Current line-control value; 0xBF unlocks configuration |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data (0 when locked) |
| ie_flow | input | 2 | Interrupt enables: [1] CTS event, [0] RTS event |
| cts_n_pin | input | 1 | CTS pin, 1 requests a transmit stop |
| rts_n_pin | output | 1 | RTS pin, 1 asks the far end to stop |
| tx_pending | input | 1 | Transmitter has a character waiting |
| tx_idle | input | 1 | Transmitter is between characters |
| tx_launch | output | 1 | Permission to start the next character |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character |
| rx_count | input | 6 | Receive FIFO occupancy |
| fifo_wr | output | 1 | Write strobe to the receive FIFO |
| fifo_wdata | output | 8 | Character for the receive FIFO |
| flag_clr | input | 1 | Clears all status flags |
| cts_flag | output | 1 | CTS flow-control event pending |
| rts_flag | output | 1 | RTS flow-control event pending |
| spec_flag | output | 1 | Special character received |
| irq_pend | output | 1 | Any flag pending |
| irq_src | output | 2 | Highest-priority pending source |

## Verification
The character matcher is driven with the Xon and Xoff codes while software flow is off and then on. This separates a matcher that always consumes those codes from one that follows the feature bit. The special register is set to 0x01 and the bench sends both 0x80 and 0x01, which exposes a reversed bit order in the compare. RTS is walked through counts on both sides of the threshold and of the release mark, including the low-threshold case where the release mark is clamped to 1. CTS is toggled with its interrupt enable on and then off, so a missing synchronizer stage or an ignored enable shows up as a wrong cycle or a stray flag.

// File: rtl/uaf_pkg.sv
package uaf_pkg;

  localparam int CHAR_W = 8;
  localparam logic [7:0] UNLOCK_KEY = 8'hBF;

  localparam logic [2:0] A_FEAT = 3'd0;
  localparam logic [2:0] A_XON  = 3'd1;
  localparam logic [2:0] A_XOFF = 3'd2;
  localparam logic [2:0] A_SPEC = 3'd3;
  localparam logic [2:0] A_THR  = 3'd4;

  localparam logic [CHAR_W-1:0] XON_RST  = 8'h11;
  localparam logic [CHAR_W-1:0] XOFF_RST = 8'h13;
  localparam logic [CHAR_W-1:0] SPEC_RST = 8'h00;

  typedef struct packed {
    logic auto_cts;
    logic auto_rts;
    logic spec_en;
    logic sw_en;
  } feat_t;

  typedef enum logic [1:0] {
    IRQ_NONE = 2'd0,
    IRQ_SPEC = 2'd1,
    IRQ_FLOW = 2'd2
  } irq_src_e;

  // Bit i of the pattern is compared against bit i of the character.
  function automatic logic chars_match(input logic [CHAR_W-1:0] rx,
                                       input logic [CHAR_W-1:0] pat);
    logic diff;
    diff = 1'b0;
    for (int i = 0; i < CHAR_W; i++) diff = diff | (rx[i] ^ pat[i]);
    return !diff;
  endfunction

  // Level below which RTS is reasserted.
  function automatic logic [15:0] rts_release_mark(input logic [15:0] thr,
                                                   input logic [15:0] hyst);
    return (thr > hyst) ? (thr - hyst) : 16'd1;
  endfunction

  function automatic irq_src_e pick_irq(input logic spec, input logic flow);
    if (spec) return IRQ_SPEC;
    if (flow) return IRQ_FLOW;
    return IRQ_NONE;
  endfunction

endpackage

// File: rtl/uaf_regs.sv
module uaf_regs
  import uaf_pkg::*;
#(
  parameter int                CNT_W   = 6,
  parameter logic [CNT_W-1:0]  THR_RST = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        line_ctl,
  input  logic              cfg_wr,
  input  logic [2:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  output feat_t             feat,
  output logic [CHAR_W-1:0] xon_chr,
  output logic [CHAR_W-1:0] xoff_chr,
  output logic [CHAR_W-1:0] spec_chr,
  output logic [CNT_W-1:0]  rts_thr
);

  logic       unlocked;
  logic [3:0] feat_q;

  assign unlocked = (line_ctl == UNLOCK_KEY);
  assign feat     = feat_t'(feat_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      feat_q   <= '0;
      xon_chr  <= XON_RST;
      xoff_chr <= XOFF_RST;
      spec_chr <= SPEC_RST;
      rts_thr  <= THR_RST;
    end else if (cfg_wr && unlocked) begin
      case (cfg_addr)
        A_FEAT:  feat_q   <= cfg_wdata[7:4];
        A_XON:   xon_chr  <= cfg_wdata;
        A_XOFF:  xoff_chr <= cfg_wdata;
        A_SPEC:  spec_chr <= cfg_wdata;
        A_THR:   rts_thr  <= cfg_wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (unlocked) begin
      case (cfg_addr)
        A_FEAT:  cfg_rdata = {feat_q, 4'b0000};
        A_XON:   cfg_rdata = xon_chr;
        A_XOFF:  cfg_rdata = xoff_chr;
        A_SPEC:  cfg_rdata = spec_chr;
        A_THR:   cfg_rdata = 8'(rts_thr);
        default: cfg_rdata = '0;
      endcase
    end
  end

  AST_LOCKED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !unlocked) |=> ($stable(feat_q) && $stable(xon_chr) && $stable(xoff_chr)
                               && $stable(spec_chr) && $stable(rts_thr))); // R2

endmodule

// File: rtl/uaf_rx_match.sv
module uaf_rx_match
  import uaf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  feat_t             feat,
  input  logic [CHAR_W-1:0] xon_chr,
  input  logic [CHAR_W-1:0] xoff_chr,
  input  logic [CHAR_W-1:0] spec_chr,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_data,
  output logic              fifo_wr,
  output logic [CHAR_W-1:0] fifo_wdata,
  output logic              xon_hit,
  output logic              xoff_hit,
  output logic              spec_hit
);

  logic flow_hit;

  assign xoff_hit = rx_valid && feat.sw_en && chars_match(rx_data, xoff_chr);
  assign xon_hit  = rx_valid && feat.sw_en && !xoff_hit && chars_match(rx_data, xon_chr);
  assign flow_hit = xon_hit || xoff_hit;
  assign spec_hit = rx_valid && feat.spec_en && !flow_hit && chars_match(rx_data, spec_chr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_wr    <= 1'b0;
      fifo_wdata <= '0;
    end else begin
      fifo_wr    <= rx_valid && !flow_hit;
      fifo_wdata <= rx_data;
    end
  end

  AST_FLOW_CHAR_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    flow_hit |=> !fifo_wr); // R7

  AST_PLAIN_CHAR_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !feat.sw_en) |=> (fifo_wr && fifo_wdata == $past(rx_data))); // R10

endmodule

// File: rtl/uaf_tx_gate.sv
module uaf_tx_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic auto_cts,
  input  logic sw_en,
  input  logic cts_n_pin,
  input  logic xon_hit,
  input  logic xoff_hit,
  input  logic tx_pending,
  input  logic tx_idle,
  output logic tx_launch,
  output logic cts_rise
);

  localparam int PIPE_W = SYNC_STAGES + 1;

  logic [PIPE_W-1:0] cts_pipe;
  logic              cts_now;
  logic              cts_prev;
  logic              sw_pause;
  logic              hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cts_pipe <= '0;
    else        cts_pipe <= {cts_pipe[PIPE_W-2:0], cts_n_pin};
  end

  assign cts_now  = cts_pipe[SYNC_STAGES-1];
  assign cts_prev = cts_pipe[SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sw_pause <= 1'b0;
    else if (!sw_en)   sw_pause <= 1'b0;
    else if (xoff_hit) sw_pause <= 1'b1;
    else if (xon_hit)  sw_pause <= 1'b0;
  end

  assign hold      = (auto_cts && cts_now) || sw_pause;
  assign tx_launch = tx_pending && tx_idle && !hold;
  assign cts_rise  = auto_cts && cts_now && !cts_prev;

  AST_XOFF_BLOCKS_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && $past(xoff_hit) && $past(sw_en)) |-> !tx_launch); // R7

  AST_LAUNCH_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_launch |-> (tx_idle && tx_pending)); // R3

  AST_CTS_EVENT_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    cts_rise |=> !cts_rise); // R4

endmodule

// File: rtl/uaf_rts_gen.sv
module uaf_rts_gen
  import uaf_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int HYST  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_rts,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] rts_thr,
  output logic             rts_n,
  output logic             rts_rise
);

  logic [15:0] lo_mark;
  logic        at_thr;
  logic        below_lo;
  logic        rts_prev;

  assign lo_mark  = rts_release_mark(16'(rts_thr), 16'(HYST));
  assign at_thr   = (rx_count >= rts_thr);
  assign below_lo = (16'(rx_count) < lo_mark);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rts_n    <= 1'b0;
      rts_prev <= 1'b0;
    end else begin
      rts_prev <= rts_n;
      if (!auto_rts)     rts_n <= 1'b0;
      else if (at_thr)   rts_n <= 1'b1;
      else if (below_lo) rts_n <= 1'b0;
    end
  end

  assign rts_rise = rts_n && !rts_prev;

  AST_RTS_STOP_AT_THRESHOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rts && rx_count >= rts_thr) |=> rts_n); // R5

  AST_RTS_LOW_WHEN_MANUAL: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_rts |=> !rts_n); // R5

endmodule

// File: rtl/uart_flow_ctl.sv
module uart_flow_ctl
  import uaf_pkg::*;
#(
  parameter int               CNT_W       = 6,
  parameter int               HYST        = 4,
  parameter int               SYNC_STAGES = 2,
  parameter logic [CNT_W-1:0] THR_RST     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       line_ctl,
  input  logic             cfg_wr,
  input  logic [2:0]       cfg_addr,
  input  logic [7:0]       cfg_wdata,
  output logic [7:0]       cfg_rdata,
  input  logic [1:0]       ie_flow,
  input  logic             cts_n_pin,
  output logic             rts_n_pin,
  input  logic             tx_pending,
  input  logic             tx_idle,
  output logic             tx_launch,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic [CNT_W-1:0] rx_count,
  output logic             fifo_wr,
  output logic [7:0]       fifo_wdata,
  input  logic             flag_clr,
  output logic             cts_flag,
  output logic             rts_flag,
  output logic             spec_flag,
  output logic             irq_pend,
  output logic [1:0]       irq_src
);

  feat_t             feat;
  logic [CHAR_W-1:0] xon_chr, xoff_chr, spec_chr;
  logic [CNT_W-1:0]  rts_thr;
  logic              xon_hit, xoff_hit, spec_hit;
  logic              cts_rise, rts_rise;
  logic              cts_evt, rts_evt;

  uaf_regs #(.CNT_W(CNT_W), .THR_RST(THR_RST)) u_regs (
    .clk, .rst_n, .line_ctl, .cfg_wr, .cfg_addr, .cfg_wdata, .cfg_rdata,
    .feat, .xon_chr, .xoff_chr, .spec_chr, .rts_thr
  );

  uaf_rx_match u_match (
    .clk, .rst_n, .feat, .xon_chr, .xoff_chr, .spec_chr,
    .rx_valid, .rx_data, .fifo_wr, .fifo_wdata,
    .xon_hit, .xoff_hit, .spec_hit
  );

  uaf_tx_gate #(.SYNC_STAGES(SYNC_STAGES)) u_txg (
    .clk, .rst_n, .auto_cts(feat.auto_cts), .sw_en(feat.sw_en), .cts_n_pin,
    .xon_hit, .xoff_hit, .tx_pending, .tx_idle, .tx_launch, .cts_rise
  );

  uaf_rts_gen #(.CNT_W(CNT_W), .HYST(HYST)) u_rts (
    .clk, .rst_n, .auto_rts(feat.auto_rts), .rx_count, .rts_thr,
    .rts_n(rts_n_pin), .rts_rise
  );

  assign cts_evt = cts_rise && ie_flow[1];
  assign rts_evt = rts_rise && ie_flow[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cts_flag  <= 1'b0;
      rts_flag  <= 1'b0;
      spec_flag <= 1'b0;
    end else begin
      cts_flag  <= cts_evt  || (cts_flag  && !flag_clr);
      rts_flag  <= rts_evt  || (rts_flag  && !flag_clr);
      spec_flag <= spec_hit || (spec_flag && !flag_clr);
    end
  end

  assign irq_pend = cts_flag || rts_flag || spec_flag;
  assign irq_src  = pick_irq(spec_flag, cts_flag || rts_flag);

  AST_SPEC_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    spec_hit |=> spec_flag); // R8

  AST_FLAGS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !spec_hit && !cts_evt && !rts_evt) |=> !irq_pend); // R9

  AST_FLOW_GATED_BY_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cts_flag && !ie_flow[1]) |=> !cts_flag); // R4

endmodule

// File: tb/uart_flow_ctl_tb.sv
module uart_flow_ctl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] line_ctl = 8'hBF;
  logic       cfg_wr = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic [1:0] ie_flow = '0;
  logic       cts_n_pin = 1'b0;
  logic       rts_n_pin;
  logic       tx_pending = 1'b0;
  logic       tx_idle = 1'b0;
  logic       tx_launch;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic [5:0] rx_count = '0;
  logic       fifo_wr;
  logic [7:0] fifo_wdata;
  logic       flag_clr = 1'b0;
  logic       cts_flag, rts_flag, spec_flag, irq_pend;
  logic [1:0] irq_src;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] exp_q[$];

  always #10 clk = ~clk;

  uart_flow_ctl u_dut (
    .clk, .rst_n, .line_ctl, .cfg_wr, .cfg_addr, .cfg_wdata, .cfg_rdata,
    .ie_flow, .cts_n_pin, .rts_n_pin, .tx_pending, .tx_idle, .tx_launch,
    .rx_valid, .rx_data, .rx_count, .fifo_wr, .fifo_wdata, .flag_clr,
    .cts_flag, .rts_flag, .spec_flag, .irq_pend, .irq_src
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    cfg_addr = a;
    #1;
    chk(req, cfg_rdata, exp);
  endtask

  // Driver: sends one character, records what the FIFO should receive.
  task automatic send_rx(input logic [7:0] d, input bit stored);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d;
    if (stored) exp_q.push_back(d);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic clear_flags();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  // Monitor: compares each FIFO write against the scoreboard queue (R10).
  always @(negedge clk) begin
    if (rst_n && fifo_wr) begin
      if (exp_q.size() == 0) chk("R10 unexpected fifo write", fifo_wdata, 32'hFFFF);
      else chk("R10 fifo data", fifo_wdata, exp_q.pop_front());
    end
  end

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rts", rts_n_pin, 0);
    chk("R1 irq_pend", irq_pend, 0);
    chk("R1 irq_src", irq_src, 0);
    chk("R1 fifo_wr", fifo_wr, 0);
    rd_chk("R1 feat", 3'd0, 8'h00);
    rd_chk("R1 xon", 3'd1, 8'h11);
    rd_chk("R1 xoff", 3'd2, 8'h13);
    rd_chk("R1 spec", 3'd3, 8'h00);
    rd_chk("R1 thr", 3'd4, 8'd8);

    // R2 access gate
    line_ctl = 8'h03;
    wr_cfg(3'd1, 8'h55);
    rd_chk("R2 locked read", 3'd1, 8'h00);
    line_ctl = 8'hBF;
    rd_chk("R2 locked write ignored", 3'd1, 8'h11);
    wr_cfg(3'd3, 8'h01);
    rd_chk("R2 unlocked write", 3'd3, 8'h01);

    // R10 / R7: flow chars are data while software flow is off
    tx_pending = 1'b1; tx_idle = 1'b1;
    send_rx(8'h41, 1);
    send_rx(8'h13, 1);
    send_rx(8'h11, 1);
    chk("R7 no pause when sw off", tx_launch, 1);

    // R7 software flow
    wr_cfg(3'd0, 8'h10);
    send_rx(8'h13, 0);
    chk("R7 xoff pauses", tx_launch, 0);
    send_rx(8'h42, 1);
    chk("R7 pause persists", tx_launch, 0);
    send_rx(8'h11, 0);
    chk("R7 xon resumes", tx_launch, 1);

    // R8 special detect, bit alignment
    wr_cfg(3'd0, 8'h20);
    send_rx(8'h80, 1);
    chk("R8 reversed bits no match", spec_flag, 0);
    send_rx(8'h01, 1);
    chk("R8 match flag", spec_flag, 1);
    chk("R9 src special", irq_src, 1);
    clear_flags();
    chk("R9 cleared", irq_pend, 0);

    // R3 / R4 auto-CTS
    wr_cfg(3'd0, 8'h80);
    ie_flow = 2'b10;
    @(negedge clk); cts_n_pin = 1'b1;
    @(negedge clk); chk("R3 one edge still open", tx_launch, 1);
    @(negedge clk); chk("R3 blocked at second edge", tx_launch, 0);
    @(negedge clk); chk("R4 cts flag", cts_flag, 1);
    chk("R9 src flow", irq_src, 2);
    tx_idle = 1'b0;
    cts_n_pin = 1'b0;
    repeat (2) @(negedge clk);
    chk("R3 busy means no launch", tx_launch, 0);
    tx_idle = 1'b1; #1;
    chk("R3 resumed", tx_launch, 1);
    clear_flags();
    ie_flow = 2'b00;
    @(negedge clk); cts_n_pin = 1'b1;
    repeat (4) @(negedge clk);
    chk("R4 masked", cts_flag, 0);
    cts_n_pin = 1'b0;
    repeat (3) @(negedge clk);

    // R9 priority: special beats flow
    wr_cfg(3'd0, 8'hA0);
    ie_flow = 2'b10;
    @(negedge clk); cts_n_pin = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 flow alone", irq_src, 2);
    send_rx(8'h01, 1);
    chk("R9 special outranks", irq_src, 1);
    cts_n_pin = 1'b0;
    clear_flags();
    chk("R9 all clear", irq_pend, 0);

    // R5 / R6 auto-RTS
    wr_cfg(3'd0, 8'h40);
    ie_flow = 2'b01;
    @(negedge clk); rx_count = 6'd7;
    @(negedge clk); chk("R5 below thr", rts_n_pin, 0);
    rx_count = 6'd8;
    @(negedge clk); chk("R5 at thr", rts_n_pin, 1);
    @(negedge clk); chk("R6 rts flag", rts_flag, 1);
    rx_count = 6'd4;
    @(negedge clk); chk("R5 hysteresis holds", rts_n_pin, 1);
    rx_count = 6'd3;
    @(negedge clk); chk("R5 released", rts_n_pin, 0);
    wr_cfg(3'd4, 8'd2);
    rx_count = 6'd2;
    @(negedge clk); chk("R5 low thr stop", rts_n_pin, 1);
    rx_count = 6'd1;
    @(negedge clk); chk("R5 low thr holds at 1", rts_n_pin, 1);
    rx_count = 6'd0;
    @(negedge clk); chk("R5 low thr release at 0", rts_n_pin, 0);
    clear_flags();
    ie_flow = 2'b00;
    rx_count = 6'd9;
    repeat (2) @(negedge clk);
    chk("R6 masked", rts_flag, 0);
    wr_cfg(3'd0, 8'h00);
    @(negedge clk); chk("R5 manual low", rts_n_pin, 0);

    repeat (2) @(negedge clk);
    chk("R10 queue drained", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule